// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is a sum-of-products logic array whose two planes are both set by a configuration map. Every product term can pick any mix of true and inverted input literals. Every output can collect any subset of the product terms, so a single term may feed several outputs. The number of product terms is a parameter and is far smaller than the number of minterms of the inputs. The array therefore holds only the terms a given function needs.

The map is loaded one bit per clock through a serial shift port while the load enable is high. During loading every output is forced low. Once the enable drops, the outputs follow the inputs combinationally through the new map. A synchronous active-low reset empties the map. With an empty map every output reads 0.

Top module: `pla_array`

## Requirements
- R1: Each output equals the OR of the product terms connected to it in the OR plane. The outputs respond combinationally to `in_vec` while `cfg_en` is low.
- R2: A product term is the AND of its selected literals. A true-select bit takes `in_vec[i]` and a complement-select bit takes `~in_vec[i]`.
- R3: A product term with no literal selected evaluates to 1.
- R4: A product term that selects both the true and the complement literal of the same input evaluates to 0 for every input value.
- R5: An output with no product term connected evaluates to 0 for every input value.
- R6: One product term connected to several outputs drives all of them.
- R7: The map holds TOTAL = P*2N + M*P bits, and serial bit k (counted from 0) lands at map index k. Index t*2N + 2i selects the true literal of input i in term t, and index t*2N + 2i + 1 selects its complement. Index P*2N + o*P + t connects term t to output o.
- R8: While `cfg_en` is high, one bit of `cfg_din` is taken per rising clock edge and `out_vec` is 0.
- R9: In the first cycle after `cfg_en` falls, the outputs are evaluated with the loaded map. While `cfg_en` stays low, `cfg_din` has no effect on the map.
- R10: A clock edge with `rst_n` low clears the whole map, after which `out_vec` is 0 for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration shift chain |
| rst_n | input | 1 | Synchronous active-low reset, clears the map |
| cfg_en | input | 1 | High while map bits are being shifted in |
| cfg_din | input | 1 | Serial map bit |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Sum-of-products outputs |

## Verification
Two hand-built maps are loaded through the serial port. The first map joins a shared two-literal term, a self-contradicting term, an empty term and a second term on output 0. Hand-chosen one-hot and paired input values therefore tell a misplaced serial bit apart from a swapped literal polarity, a missing term share, or a wrong empty-term value. The second map leaves three outputs unconnected, which separates a floating OR from a correct 0. Random inputs during and after each load are compared against a behavioural model on every cycle. These random-input checks separate output gating during loading, use of the map in the first cycle after loading, immunity to `cfg_din` while idle, and clearing by reset.

// File: rtl/pla_pkg.sv
// Package: map index arithmetic shared by the array's submodules.
// Assumes the map layout of the brief: AND plane first, then OR plane.
package pla_pkg;

    // Index of the AND-plane bit for term t, input i, polarity comp (1 = inverted).
    function automatic int unsigned and_idx(int unsigned n_in, int unsigned t,
                                            int unsigned i, int unsigned comp);
        return t * 2 * n_in + 2 * i + comp;
    endfunction

    // Number of bits in the whole AND plane.
    function automatic int unsigned and_bits(int unsigned n_in, int unsigned n_term);
        return n_term * 2 * n_in;
    endfunction

    // Number of bits in the whole OR plane.
    function automatic int unsigned or_bits(int unsigned n_term, int unsigned n_out);
        return n_out * n_term;
    endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
// Module: serial configuration chain holding the full connection map.
// Shifts toward index 0, so the first bit loaded ends at index 0 after
// TOTAL shifts. Holds its content while shift_en is low.
module pla_cfg_chain #(
    parameter int unsigned TOTAL = 320
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             shift_din,
    output logic [TOTAL-1:0] map_q
);

    // Clear on reset, otherwise shift one bit in per enabled clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (shift_en) begin
            map_q <= {shift_din, map_q[TOTAL-1:1]};
        end
    end

    // R10
    map_clear_chk: assert property (@(posedge clk) !rst_n |=> map_q == '0);

    // R8
    shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> map_q[TOTAL-1] == $past(shift_din));

    // R9
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(map_q));

endmodule

// File: rtl/pla_and_plane.sv
// Module: AND plane. Each term ANDs the literals its mask selects.
// Literal 2i is in[i], literal 2i+1 is ~in[i]. An unselected literal
// is treated as 1, so an empty mask yields a term of 1.
module pla_and_plane #(
    parameter int unsigned N_IN   = 8,
    parameter int unsigned N_TERM = 16
) (
    input  logic [N_IN-1:0]          in_vec,
    input  logic [N_TERM*2*N_IN-1:0] and_mask,
    output logic [N_TERM-1:0]        term_o
);
    localparam int unsigned LITS = 2 * N_IN;

    logic [LITS-1:0] lits;

    // Build the true/complement literal pair for every input.
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            lits[2*i]   = in_vec[i];
            lits[2*i+1] = ~in_vec[i];
        end
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        localparam int unsigned BASE = pla_pkg::and_idx(N_IN, t, 0, 0);
        logic [LITS-1:0] sel;
        assign sel = and_mask[BASE +: LITS];
        // Unselected literals pass 1; selected ones must be true.
        assign term_o[t] = &(lits | ~sel);
    end

endmodule

// File: rtl/pla_or_plane.sv
// Module: OR plane. Each output ORs the terms its mask connects and is
// forced to 0 while hold is high. An empty mask yields 0.
module pla_or_plane #(
    parameter int unsigned N_TERM = 16,
    parameter int unsigned N_OUT  = 4
) (
    input  logic [N_TERM-1:0]       term_i,
    input  logic [N_OUT*N_TERM-1:0] or_mask,
    input  logic                    hold,
    output logic [N_OUT-1:0]        out_vec
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [N_TERM-1:0] conn;
        assign conn = or_mask[o*N_TERM +: N_TERM];
        // Collect connected terms unless the map is being loaded.
        assign out_vec[o] = !hold && (|(term_i & conn));
    end

endmodule

// File: rtl/pla_array.sv
// Module: top of the programmable AND-OR array. A serial chain holds
// the AND-plane mask (low indices) and the OR-plane mask (high indices).
// Assumes cfg_en and cfg_din are synchronous to clk; in_vec may change freely.
module pla_array #(
    parameter int unsigned N_IN   = 8,
    parameter int unsigned N_TERM = 16,
    parameter int unsigned N_OUT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] out_vec
);
    localparam int unsigned AND_W = pla_pkg::and_bits(N_IN, N_TERM);
    localparam int unsigned OR_W  = pla_pkg::or_bits(N_TERM, N_OUT);
    localparam int unsigned TOTAL = AND_W + OR_W;

    logic [TOTAL-1:0]  map_q;
    logic [AND_W-1:0]  and_mask;
    logic [OR_W-1:0]   or_mask;
    logic [N_TERM-1:0] terms;

    assign and_mask = map_q[AND_W-1:0];
    assign or_mask  = map_q[TOTAL-1:AND_W];

    pla_cfg_chain #(.TOTAL(TOTAL)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .shift_din(cfg_din),
        .map_q    (map_q)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .in_vec  (in_vec),
        .and_mask(and_mask),
        .term_o  (terms)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .term_i (terms),
        .or_mask(or_mask),
        .hold   (cfg_en),
        .out_vec(out_vec)
    );

    // R8
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> out_vec == '0);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term_chk
        // Check empty and self-contradicting terms against the mask.
        always_comb begin
            logic clash;
            clash = 1'b0;
            for (int i = 0; i < N_IN; i++) begin
                clash = clash | (and_mask[pla_pkg::and_idx(N_IN, t, i, 0)] &
                                 and_mask[pla_pkg::and_idx(N_IN, t, i, 1)]);
            end
            // R3
            if (and_mask[t*2*N_IN +: 2*N_IN] == '0) empty_term_chk: assert (terms[t] == 1'b1);
            // R4
            if (clash) clash_term_chk: assert (terms[t] == 1'b0);
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out_chk
        // R5: an output with nothing connected stays low.
        always_comb begin
            if (or_mask[o*N_TERM +: N_TERM] == '0) empty_out_chk: assert (out_vec[o] == 1'b0);
        end
    end

endmodule

// File: tb/sim_pla_array.sv
// Bench: behavioural model of the map and evaluation, compared every cycle.
module sim_pla_array;
    localparam int N = 8;
    localparam int P = 16;
    localparam int M = 4;
    localparam int AW = P * 2 * N;
    localparam int TOT = AW + M * P;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic cfg_din = 1'b0;
    logic [N-1:0] in_vec = '0;
    logic [M-1:0] out_vec;

    int vectors = 0;
    int fails = 0;

    bit ref_map [TOT];
    bit cfg_bits [TOT];

    pla_array #(.N_IN(N), .N_TERM(P), .N_OUT(M)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .in_vec(in_vec), .out_vec(out_vec)
    );

    always #4 clk = ~clk;

    // Model of the map: cleared by reset, shifted while loading.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (ref_map[k]) ref_map[k] = 1'b0;
        end else if (cfg_en) begin
            for (int k = 0; k < TOT - 1; k++) ref_map[k] = ref_map[k+1];
            ref_map[TOT-1] = cfg_din;
        end
    end

    function automatic logic [M-1:0] ref_eval(logic [N-1:0] x, logic en);
        logic [M-1:0] r;
        r = '0;
        if (en) return r;
        for (int o = 0; o < M; o++) begin
            for (int t = 0; t < P; t++) begin
                bit prod;
                prod = 1'b1;
                for (int i = 0; i < N; i++) begin
                    if (ref_map[t*2*N + 2*i] && !x[i]) prod = 1'b0;
                    if (ref_map[t*2*N + 2*i + 1] && x[i]) prod = 1'b0;
                end
                if (ref_map[AW + o*P + t] && prod) r[o] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic check(string tag, logic [M-1:0] exp);
        vectors++;
        if (out_vec !== exp) begin
            fails++;
            $display("FAIL %s: out_vec=%b expected %b", tag, out_vec, exp);
        end
    endtask

    task automatic apply(logic en, logic din, logic [N-1:0] vin, string tag);
        @(negedge clk);
        cfg_en = en; cfg_din = din; in_vec = vin;
        #2;
        check(tag, ref_eval(vin, en));
    endtask

    task automatic hand(logic [N-1:0] vin, logic [M-1:0] exp, string tag);
        @(negedge clk);
        cfg_en = 1'b0; in_vec = vin;
        #2;
        check(tag, exp);
        check({tag, " model"}, ref_eval(vin, 1'b0));
    endtask

    task automatic clear_cfg();
        foreach (cfg_bits[k]) cfg_bits[k] = 1'b0;
    endtask

    task automatic sel_lit(int t, int i, int comp);
        cfg_bits[t*2*N + 2*i + comp] = 1'b1;
    endtask

    task automatic conn(int o, int t);
        cfg_bits[AW + o*P + t] = 1'b1;
    endtask

    task automatic load_cfg();
        for (int k = 0; k < TOT; k++) apply(1'b1, cfg_bits[k], N'($urandom), "R8");
        apply(1'b0, 1'b0, N'($urandom), "R9 first cycle");
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk); in_vec = 8'hFF; #2;
        check("R10 reset state", 4'b0000);
        rst_n = 1'b1;

        // Map A: shared term, clash term, empty term, second OR term.
        clear_cfg();
        sel_lit(0, 0, 0); sel_lit(0, 1, 1); conn(0, 0); conn(1, 0);
        sel_lit(1, 2, 0); sel_lit(1, 2, 1); conn(2, 1);
        sel_lit(3, 3, 0); conn(2, 3);
        conn(3, 2);
        sel_lit(4, 6, 0); sel_lit(4, 7, 1); conn(0, 4);
        load_cfg();

        hand(8'h01, 4'b1011, "R6 R7 shared term");
        hand(8'h03, 4'b1000, "R2 complement literal");
        hand(8'h02, 4'b1000, "R3 empty term");
        hand(8'h04, 4'b1000, "R4 clash term");
        hand(8'h0C, 4'b1100, "R4 clash with in3");
        hand(8'h40, 4'b1001, "R1 second term");
        hand(8'hC0, 4'b1000, "R2 in7 blocks term4");
        hand(8'h41, 4'b1011, "R1 both terms");

        for (int k = 0; k < 200; k++) apply(1'b0, k[0], N'($urandom), "R1 R2 R9 random");
        hand(8'h01, 4'b1011, "R9 din ignored");

        // Map B: only output 1 connected, to a single-literal term.
        clear_cfg();
        sel_lit(5, 7, 0); conn(1, 5);
        load_cfg();
        hand(8'h80, 4'b0010, "R5 single output");
        hand(8'h7F, 4'b0000, "R5 empty outputs");
        for (int k = 0; k < 200; k++) apply(1'b0, 1'b0, N'($urandom), "R5 random");

        // Reset with a loaded map.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        hand(8'h80, 4'b0000, "R10 after reset");
        for (int k = 0; k < 50; k++) apply(1'b0, 1'b1, N'($urandom), "R10 random");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule